// File: doc/BRIEF.md
# Dual-Calendar Port Slot Sequencer

This block supplies the port number for every slot of a status channel. It keeps two slot tables. In each table an entry holds a port address, and a port that occupies more entries gets a larger share of the channel. Each time the channel logic pulses the slot-advance strobe, the sequencer reports the next entry of the active table. It marks the first entry of every pass with a start flag and wraps back to entry 0 after the programmed last entry.

Software uses a small register file to set up the block after reset. The tables power up with unknown contents, so software first writes a slot address into a pointer register. It then writes the port value into the data register of the table it is filling. It also sets a length for each table, chooses which table is active, and switches the channel on or off. A change of table takes effect only when the current pass ends, so the channel bandwidth can be reallocated without a break. Writes that carry illegal values are dropped and set a sticky error bit.

Register addresses, all 16-bit:

| Address | Register | Bits |
|---|---|---|
| 0 | CTRL | bit0 channel off (reset 1), bit1 requested table, bit2 active table (read only), bit3 sticky error (read); writing 1 to bit3 clears the error |
| 1 | LEN0 | length of table 0 minus one |
| 2 | LEN1 | length of table 1 minus one |
| 3 | SADR | slot pointer |
| 4 | DAT0 | entry of table 0 at SADR |
| 5 | DAT1 | entry of table 1 at SADR |

Any other address reads as 0.

Top module: `dual_cal_sequencer`

## Requirements
- R1: After reset, CTRL reads 0x0001 (channel off, table 0 requested and active, no error), and slot_valid is 0.
- R2: A write to DAT0 or DAT1 stores the low PORT_W bits into the entry addressed by SADR of table 0 or table 1. A read of the same register returns that entry. A read returns its data on reg_rdata in the cycle after the read strobe.
- R3: LEN0 and LEN1 hold the last slot index of their table (length minus one). A read returns the written value.
- R4: While the channel is on, each cycle with slot_adv high makes slot_valid high in the next cycle. In that cycle slot_port carries the entry at the current index of the active table. The index then advances and returns to 0 after the last index. In a cycle that follows no strobe, slot_valid is 0.
- R5: slot_sof is high together with slot_valid exactly when the reported entry is index 0.
- R6: While the channel is off, slot_valid stays 0 whatever slot_adv does, and the index is held at 0. After the channel is switched back on, the first reported slot is index 0 with slot_sof high.
- R7: A change of the requested table while the channel is on takes effect only after the last entry of the current pass has been reported. While the channel is off, the change takes effect at once. CTRL bit2 shows the table in use.
- R8: A DAT0 or DAT1 write whose value is NUM_PORTS or more leaves the table entry unchanged and sets the error bit.
- R9: A write to SADR, LEN0 or LEN1 with a value of MAX_LEN or more leaves that register unchanged and sets the error bit.
- R10: The error bit stays set through later valid writes. A CTRL write with bit3 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| slot_adv | input | 1 | Advance to the next calendar slot |
| slot_valid | output | 1 | slot_port and slot_sof are valid |
| slot_port | output | PORT_W = clog2(NUM_PORTS) | Port address of the reported slot |
| slot_sof | output | 1 | Reported slot is index 0 of its table |

## Verification
The bench loads a five-entry table (0,3,2,3,1) and a three-entry table (1,2,3). It runs several passes and checks that the start flag comes back on each wrap. A design that wrapped one slot too early or too late would break the repeat of the sequence. The bench requests a table change two slots into a pass and expects the other three entries of the old table before the new one starts. A design that switched tables at once would mix entries from both tables within one pass. It also switches the channel off part way through a pass and checks that the next slot after turning it back on is index 0. Finally, it writes an out-of-range port, slot pointer and length, and reads back the old values. It checks that the error bit survives a later valid write and clears only on request.

// File: rtl/cal_pkg.sv
// Package: shared register map and control-bit positions for the
// dual-calendar slot sequencer.
package cal_pkg;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_LEN0 = 3'd1,
        RA_LEN1 = 3'd2,
        RA_SADR = 3'd3,
        RA_DAT0 = 3'd4,
        RA_DAT1 = 3'd5
    } reg_addr_e;

    localparam int CB_OFF = 0;
    localparam int CB_SEL = 1;
    localparam int CB_ACT = 2;
    localparam int CB_ERR = 3;

    localparam int REG_DW = 16;

endpackage

// File: rtl/cal_table.sv
// Module: cal_table
// One slot-to-port table. It has a single write port and two
// asynchronous read ports, one for software and one for the sequencer.
// Assumes: the contents are not reset; software fills them before use.
module cal_table #(
    parameter int NUM_PORTS = 4,
    parameter int MAX_LEN   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(MAX_LEN)-1:0]   waddr,
    input  logic [$clog2(NUM_PORTS)-1:0] wdata,
    input  logic [$clog2(MAX_LEN)-1:0]   raddr_a,
    output logic [$clog2(NUM_PORTS)-1:0] q_a,
    input  logic [$clog2(MAX_LEN)-1:0]   raddr_b,
    output logic [$clog2(NUM_PORTS)-1:0] q_b
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    logic [PORT_W-1:0] mem [MAX_LEN];

    // Store the entry at the addressed slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the entries for software and for the sequencer.
    always_comb begin
        q_a = mem[raddr_a];
        q_b = mem[raddr_b];
    end

    // R2
    table_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/cal_regs.sv
// Module: cal_regs
// Register file: channel control, table select, table lengths, slot
// pointer, table data access and the sticky error bit. It range-checks
// every write and drops illegal ones.
// Assumes: the read data is registered and appears one cycle after reg_rd.
module cal_regs
    import cal_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MAX_LEN   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [2:0]                   reg_addr,
    input  logic [REG_DW-1:0]            reg_wdata,
    output logic [REG_DW-1:0]            reg_rdata,
    output logic                         ch_off,
    output logic                         sel_req,
    output logic [$clog2(MAX_LEN)-1:0]   last0,
    output logic [$clog2(MAX_LEN)-1:0]   last1,
    output logic [$clog2(MAX_LEN)-1:0]   sadr,
    output logic [1:0]                   tbl_we,
    output logic [$clog2(NUM_PORTS)-1:0] tbl_wdata,
    input  logic [$clog2(NUM_PORTS)-1:0] tbl_q0,
    input  logic [$clog2(NUM_PORTS)-1:0] tbl_q1,
    input  logic                         act_cal
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int SLOT_W = $clog2(MAX_LEN);

    logic              err;
    logic              bad_port;
    logic              bad_slot;
    logic              wr_dat0;
    logic              wr_dat1;
    logic [REG_DW-1:0] rd_mux;

    // Decode the range checks and table write enables.
    always_comb begin
        bad_port  = 32'(reg_wdata) >= NUM_PORTS;
        bad_slot  = 32'(reg_wdata) >= MAX_LEN;
        wr_dat0   = reg_wr && (reg_addr == RA_DAT0);
        wr_dat1   = reg_wr && (reg_addr == RA_DAT1);
        tbl_we    = {wr_dat1 && !bad_port, wr_dat0 && !bad_port};
        tbl_wdata = reg_wdata[PORT_W-1:0];
    end

    // Update the control and configuration registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_off  <= 1'b1;
            sel_req <= 1'b0;
            last0   <= '0;
            last1   <= '0;
            sadr    <= '0;
            err     <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    ch_off  <= reg_wdata[CB_OFF];
                    sel_req <= reg_wdata[CB_SEL];
                    if (reg_wdata[CB_ERR]) err <= 1'b0;
                end
                RA_LEN0: if (bad_slot) err <= 1'b1; else last0 <= reg_wdata[SLOT_W-1:0];
                RA_LEN1: if (bad_slot) err <= 1'b1; else last1 <= reg_wdata[SLOT_W-1:0];
                RA_SADR: if (bad_slot) err <= 1'b1; else sadr  <= reg_wdata[SLOT_W-1:0];
                RA_DAT0, RA_DAT1: if (bad_port) err <= 1'b1;
                default: ;
            endcase
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            RA_CTRL: begin
                rd_mux[CB_OFF] = ch_off;
                rd_mux[CB_SEL] = sel_req;
                rd_mux[CB_ACT] = act_cal;
                rd_mux[CB_ERR] = err;
            end
            RA_LEN0: rd_mux = REG_DW'(last0);
            RA_LEN1: rd_mux = REG_DW'(last1);
            RA_SADR: rd_mux = REG_DW'(sadr);
            RA_DAT0: rd_mux = REG_DW'(tbl_q0);
            RA_DAT1: rd_mux = REG_DW'(tbl_q1);
            default: rd_mux = '0;
        endcase
    end

    // Register the read data when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R8
    bad_port_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_dat0 || wr_dat1) && bad_port) |=> err);

    // R9
    bad_sadr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_SADR && bad_slot) |=> $stable(sadr));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == RA_CTRL)) |=> err);

endmodule

// File: rtl/cal_seq.sv
// Module: cal_seq
// Slot sequencer: steps through the active table once per advance
// strobe, flags index 0, and takes up a requested table change only at
// the end of a pass or while the channel is off.
// Assumes: the table read data is combinational on the index.
module cal_seq #(
    parameter int NUM_PORTS = 4,
    parameter int MAX_LEN   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ch_off,
    input  logic                         sel_req,
    input  logic [$clog2(MAX_LEN)-1:0]   last0,
    input  logic [$clog2(MAX_LEN)-1:0]   last1,
    input  logic                         slot_adv,
    input  logic [$clog2(NUM_PORTS)-1:0] q0,
    input  logic [$clog2(NUM_PORTS)-1:0] q1,
    output logic [$clog2(MAX_LEN)-1:0]   idx,
    output logic                         act_cal,
    output logic                         slot_valid,
    output logic [$clog2(NUM_PORTS)-1:0] slot_port,
    output logic                         slot_sof
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int SLOT_W = $clog2(MAX_LEN);

    logic [SLOT_W-1:0] last_idx;
    logic              at_end;

    // Find the last index of the active table.
    always_comb begin
        last_idx = act_cal ? last1 : last0;
        at_end   = idx >= last_idx;
    end

    // Advance the index, emit slots, and switch tables at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            act_cal    <= 1'b0;
            slot_valid <= 1'b0;
            slot_port  <= '0;
            slot_sof   <= 1'b0;
        end else if (ch_off) begin
            idx        <= '0;
            act_cal    <= sel_req;
            slot_valid <= 1'b0;
            slot_sof   <= 1'b0;
        end else begin
            slot_valid <= slot_adv;
            slot_sof   <= slot_adv && (idx == '0);
            if (slot_adv) begin
                slot_port <= act_cal ? q1 : q0;
                if (at_end) begin
                    idx     <= '0;
                    act_cal <= sel_req;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R6
    off_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_off |=> (!slot_valid && idx == '0));

    // R4
    no_strobe_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_adv |=> !slot_valid);

    // R5
    sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_sof |-> slot_valid);

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_off && !slot_adv) |=> $stable(act_cal));

    // R4
    port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (32'(slot_port) < NUM_PORTS));

endmodule

// File: rtl/dual_cal_sequencer.sv
// Module: dual_cal_sequencer
// Top level: a register file, two slot tables built by a generate loop,
// and the slot sequencer.
// Assumes: software writes both tables after reset, before the channel
// is switched on. NUM_PORTS >= 2 and MAX_LEN >= 2.
module dual_cal_sequencer
    import cal_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MAX_LEN   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [2:0]                   reg_addr,
    input  logic [15:0]                  reg_wdata,
    output logic [15:0]                  reg_rdata,
    input  logic                         slot_adv,
    output logic                         slot_valid,
    output logic [$clog2(NUM_PORTS)-1:0] slot_port,
    output logic                         slot_sof
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int SLOT_W = $clog2(MAX_LEN);
    localparam int N_CAL  = 2;

    logic                          ch_off;
    logic                          sel_req;
    logic                          act_cal;
    logic [SLOT_W-1:0]             last0;
    logic [SLOT_W-1:0]             last1;
    logic [SLOT_W-1:0]             sadr;
    logic [SLOT_W-1:0]             idx;
    logic [N_CAL-1:0]              tbl_we;
    logic [PORT_W-1:0]             tbl_wdata;
    logic [N_CAL-1:0][PORT_W-1:0]  sw_q;
    logic [N_CAL-1:0][PORT_W-1:0]  seq_q;

    cal_regs #(.NUM_PORTS(NUM_PORTS), .MAX_LEN(MAX_LEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ch_off    (ch_off),
        .sel_req   (sel_req),
        .last0     (last0),
        .last1     (last1),
        .sadr      (sadr),
        .tbl_we    (tbl_we),
        .tbl_wdata (tbl_wdata),
        .tbl_q0    (sw_q[0]),
        .tbl_q1    (sw_q[1]),
        .act_cal   (act_cal)
    );

    for (genvar c = 0; c < N_CAL; c++) begin : g_tbl
        cal_table #(.NUM_PORTS(NUM_PORTS), .MAX_LEN(MAX_LEN)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (tbl_we[c]),
            .waddr   (sadr),
            .wdata   (tbl_wdata),
            .raddr_a (sadr),
            .q_a     (sw_q[c]),
            .raddr_b (idx),
            .q_b     (seq_q[c])
        );
    end

    cal_seq #(.NUM_PORTS(NUM_PORTS), .MAX_LEN(MAX_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_off     (ch_off),
        .sel_req    (sel_req),
        .last0      (last0),
        .last1      (last1),
        .slot_adv   (slot_adv),
        .q0         (seq_q[0]),
        .q1         (seq_q[1]),
        .idx        (idx),
        .act_cal    (act_cal),
        .slot_valid (slot_valid),
        .slot_port  (slot_port),
        .slot_sof   (slot_sof)
    );

endmodule

// File: tb/dual_cal_sequencer_test.sv
`timescale 1ns/1ps
module dual_cal_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        slot_adv = 1'b0;
    logic        slot_valid;
    logic [1:0]  slot_port;
    logic        slot_sof;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dual_cal_sequencer #(.NUM_PORTS(4), .MAX_LEN(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_adv(slot_adv), .slot_valid(slot_valid), .slot_port(slot_port),
        .slot_sof(slot_sof)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, int'(reg_rdata), exp);
    endtask

    // One strobe; check valid, port and start flag in the following cycle.
    task automatic adv_chk(input int port, input int sof, input string tag);
        @(negedge clk);
        slot_adv = 1'b1;
        @(negedge clk);
        slot_adv = 1'b0;
        chk({tag, " valid"}, int'(slot_valid), 1);
        chk({tag, " port"}, int'(slot_port), port);
        chk({tag, " sof"}, int'(slot_sof), sof);
    endtask

    task automatic adv_none(input string tag);
        @(negedge clk);
        slot_adv = 1'b1;
        @(negedge clk);
        slot_adv = 1'b0;
        chk(tag, int'(slot_valid), 0);
    endtask

    task automatic t_reset;
        rd_chk(0, 16'h0001, "R1 ctrl after reset");
        chk("R1 valid after reset", int'(slot_valid), 0);
        adv_none("R6 strobe while off after reset");
    endtask

    task automatic t_program;
        int c0 [5] = '{0, 3, 2, 3, 1};
        int c1 [3] = '{1, 2, 3};
        wr(1, 4);
        wr(2, 2);
        rd_chk(1, 4, "R3 len0 readback");
        rd_chk(2, 2, "R3 len1 readback");
        for (int i = 0; i < 5; i++) begin
            wr(3, i);
            wr(4, c0[i]);
            if (i < 3) wr(5, c1[i]);
        end
        wr(3, 1);
        rd_chk(4, 3, "R2 table0 slot1");
        rd_chk(5, 2, "R2 table1 slot1");
        wr(3, 4);
        rd_chk(4, 1, "R2 table0 slot4");
    endtask

    task automatic t_errors;
        wr(3, 2);
        wr(4, 4);
        rd_chk(4, 2, "R8 table0 entry kept");
        rd_chk(0, 16'h0009, "R8 error set");
        wr(5, 3);
        rd_chk(5, 3, "R2 table1 slot2");
        rd_chk(0, 16'h0009, "R10 error sticky");
        wr(0, 16'h0009);
        rd_chk(0, 16'h0001, "R10 error cleared");
        wr(3, 16);
        rd_chk(3, 2, "R9 sadr kept");
        rd_chk(0, 16'h0009, "R9 sadr error");
        wr(0, 16'h0009);
        wr(1, 16);
        rd_chk(1, 4, "R9 len0 kept");
        rd_chk(0, 16'h0009, "R9 len error");
        wr(0, 16'h0009);
    endtask

    task automatic t_run0;
        int c0 [5] = '{0, 3, 2, 3, 1};
        wr(0, 0);
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 5; i++)
                adv_chk(c0[i], (i == 0) ? 1 : 0, "R4 table0 pass");
        @(negedge clk);
        chk("R4 no strobe no valid", int'(slot_valid), 0);
    endtask

    task automatic t_switch;
        adv_chk(0, 1, "R5 pass start");
        adv_chk(3, 0, "R4 slot1");
        wr(0, 16'h0002);
        rd_chk(0, 16'h0002, "R7 active unchanged mid pass");
        adv_chk(2, 0, "R7 old table slot2");
        adv_chk(3, 0, "R7 old table slot3");
        adv_chk(1, 0, "R7 old table slot4");
        rd_chk(0, 16'h0006, "R7 active switched");
        adv_chk(1, 1, "R7 new table slot0");
        adv_chk(2, 0, "R7 new table slot1");
        adv_chk(3, 0, "R7 new table slot2");
        adv_chk(1, 1, "R5 new table wrap");
    endtask

    task automatic t_disable;
        wr(0, 16'h0003);
        adv_none("R6 strobe while off");
        wr(0, 16'h0002);
        adv_chk(1, 1, "R6 restart at slot0");
        adv_chk(2, 0, "R6 restart slot1");
        wr(0, 16'h0001);
        rd_chk(0, 16'h0001, "R7 switch while off");
        wr(0, 16'h0000);
        adv_chk(0, 1, "R6 restart table0");
        adv_chk(3, 0, "R6 restart table0 slot1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_errors();
        t_run0();
        t_switch();
        t_disable();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule